// File: doc/BRIEF.md
# MDIO Management Master with Register Window

This block is the management-bus master of an Ethernet subsystem. It produces the management clock (MDC) and drives or samples the bidirectional management data line so that software can reach the registers of attached PHYs. Both the short frame format (Clause 22) and the extended, indirectly addressed format (Clause 45) are served by one frame engine. A configuration bit in the status register selects between them.

Software sees four 32-bit registers. They follow a block of twelve reserved words and are addressed by word index. A status register carries progress flags, the clause select and the clock divider. A control register holds the PHY port, the device or register number and the mode bits. A data register carries write data out and read data back. An address register holds the extended register address. Each kind of register write launches its own frame: an address write launches an address frame, a data write launches a write frame, and a control write with the read bit set launches a read frame. The pin side is a plain tri-state split (output, output enable, input) that the pad ring combines with a pull-up.

Top module: `mdio_master_ctrl`

## Requirements
- R1: After reset, every register reads zero, MDC is low and the output enable is low.
- R2: The status register is at word index 12, control at 13, data at 14 and address at 15. Indices 0 to 11 read zero. Status layout: bit 0 busy, bit 1 read error, bit 6 extended-format select, bits 15:8 divider. Control layout: bits 4:0 device/register number, bits 9:5 port, bit 10 preamble skip, bit 11 scan, bit 14 post-increment, bit 15 read launch.
- R3: With a divider field value d, MDC is high for d clock cycles and low for d clock cycles, and d = 0 behaves as 1. MDC stays low whenever no frame is in progress.
- R4: Each frame begins with 32 one-bits of preamble, unless control bit 10 is set, in which case the frame has only its 32 body bits.
- R5: In Clause 22 mode, a data write sends start 01, opcode 01, the port, the register number, turnaround 10 and the low 16 data bits, all most significant bit first.
- R6: In Clause 22 mode, a control write with bit 15 set sends start 01 and opcode 10. When the frame ends, the data register's low 16 bits hold the 16 bits sampled from the PHY.
- R7: In Clause 45 mode, an address-register write sends start 00, opcode 00, the port, the device, turnaround 10 and the written 16 bits. In Clause 22 mode, the same write only stores the value.
- R8: In Clause 45 mode, a data write uses opcode 01, and a read uses opcode 11, or 10 when control bit 14 is set.
- R9: Status bit 0 and data bit 31 read 1 from the cycle after a launching write until the frame's last MDC falling edge.
- R10: If the PHY does not drive the second turnaround bit of a read low, status bit 1 is set. It clears when the next frame is launched.
- R11: While busy, data writes, address writes and control writes with bit 15 set are ignored: no frame is launched and no register changes.
- R12: The master changes its output only while MDC is low, and drives the line only during a frame. In a read it releases the line from the first turnaround bit to the end of the frame.
- R13: The scan bit (11) and the post-increment bit (14) are stored and read back from the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives the line |

## Verification
The hardest situation to reach is a read whose turnaround goes wrong. The PHY must hold the line high exactly on the second turnaround bit, and the error flag must then be seen to clear at the next launch. The bench models a PHY that counts MDC rising edges from the start of the frame and drives its reply on each falling edge. A flag chooses what it drives in the turnaround slot. A second situation that is hard to reach is a write arriving in the middle of a frame. The bench issues it while the MDC count shows the frame is partway through, and then checks both the frame length and the register contents.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BODY_LEN = 32;

  typedef enum logic [1:0] {FK_NONE, FK_WRITE, FK_READ, FK_ADDR} frame_kind_e;

  // Build the 32 body bits sent after the preamble, most significant bit first
  function automatic logic [31:0] build_body(input logic        ext,
                                             input frame_kind_e kind,
                                             input logic        post_inc,
                                             input logic [4:0]  port,
                                             input logic [4:0]  dev,
                                             input logic [15:0] payload);
    logic [1:0] st;
    logic [1:0] op;
    st = ext ? 2'b00 : 2'b01;
    if (ext) begin
      case (kind)
        FK_ADDR:  op = 2'b00;
        FK_WRITE: op = 2'b01;
        FK_READ:  op = post_inc ? 2'b10 : 2'b11;
        default:  op = 2'b00;
      endcase
    end else begin
      op = (kind == FK_READ) ? 2'b10 : 2'b01;
    end
    return {st, op, port, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half == '0) ? DIV_W'(1) : half;
  assign tick = run && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      body,
  input  logic             is_read,
  input  logic             skip_pre,
  input  logic [DIV_W-1:0] half,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rd_done,
  output logic [15:0]      rd_value,
  output logic             rd_err
);
  localparam int PRE_W = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;
  localparam int IDX_W = $clog2(BODY_LEN);
  localparam logic [IDX_W-1:0] TA_FIRST = IDX_W'(14);
  localparam logic [IDX_W-1:0] TA_LAST  = IDX_W'(15);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(BODY_LEN - 1);

  typedef enum logic [1:0] {E_IDLE, E_PRE, E_BODY} eng_state_e;

  eng_state_e       st;
  logic             phase;
  logic [PRE_W-1:0] pre_cnt;
  logic [IDX_W-1:0] idx;
  logic [31:0]      shreg;
  logic [15:0]      rd_sh;
  logic [DIV_W-1:0] half_q;
  logic             read_q;
  logic             tick;

  mdio_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st != E_IDLE),
    .half (half_q),
    .tick (tick)
  );

  assign busy     = (st != E_IDLE);
  assign mdc      = busy && phase;
  assign mdio_oe  = (st == E_PRE) || ((st == E_BODY) && !(read_q && idx >= TA_FIRST));
  assign mdio_o   = mdio_oe && ((st == E_PRE) || shreg[31]);
  assign rd_value = rd_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      phase   <= 1'b0;
      pre_cnt <= '0;
      idx     <= '0;
      shreg   <= '0;
      rd_sh   <= '0;
      half_q  <= '0;
      read_q  <= 1'b0;
      rd_done <= 1'b0;
      rd_err  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (st == E_IDLE) begin
        if (start) begin
          st      <= skip_pre ? E_BODY : E_PRE;
          shreg   <= body;
          read_q  <= is_read;
          half_q  <= half;
          pre_cnt <= PRE_W'(PRE_LEN - 1);
          idx     <= '0;
          phase   <= 1'b0;
          rd_err  <= 1'b0;
        end
      end else if (tick) begin
        if (!phase) begin
          // rising MDC: sample the PHY during a read
          phase <= 1'b1;
          if (st == E_BODY && read_q) begin
            if (idx == TA_LAST && mdio_i) rd_err <= 1'b1;
            if (idx > TA_LAST) rd_sh <= {rd_sh[14:0], mdio_i};
            if (idx == IDX_END) rd_done <= 1'b1;
          end
        end else begin
          // falling MDC: advance to the next bit
          phase <= 1'b0;
          if (st == E_PRE) begin
            if (pre_cnt == '0) st <= E_BODY;
            else               pre_cnt <= pre_cnt - PRE_W'(1);
          end else if (idx == IDX_END) begin
            st <= E_IDLE;
          end else begin
            idx   <= idx + IDX_W'(1);
            shreg <= {shreg[30:0], 1'b0};
          end
        end
      end
    end
  end

  // R12
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R12
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o) && $stable(mdio_oe));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rd_err);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RSV_WORDS = 12,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              rd_err,
  input  logic              rd_done,
  input  logic [15:0]       rd_value,
  output logic              start,
  output logic [31:0]       body,
  output logic              is_read,
  output logic              skip_pre,
  output logic [DIV_W-1:0]  half
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RSV_WORDS);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(RSV_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(RSV_WORDS + 2);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(RSV_WORDS + 3);

  logic             ext_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       dev_q;
  logic [4:0]       port_q;
  logic             pre_dis_q;
  logic             scan_q;
  logic             pinc_q;
  logic [15:0]      data_q;
  logic [15:0]      addr_q;

  frame_kind_e kind;
  logic        ctl_wr;
  logic [4:0]  l_port;
  logic [4:0]  l_dev;
  logic        l_pinc;
  logic [15:0] payload;

  assign ctl_wr = wr && (addr == A_CTL);

  always_comb begin
    kind = FK_NONE;
    if (wr && !busy) begin
      if (addr == A_DATA)                  kind = FK_WRITE;
      else if (addr == A_ADDR && ext_q)    kind = FK_ADDR;
      else if (addr == A_CTL && wdata[15]) kind = FK_READ;
    end
  end

  always_comb begin
    l_port   = ctl_wr ? wdata[9:5] : port_q;
    l_dev    = ctl_wr ? wdata[4:0] : dev_q;
    l_pinc   = ctl_wr ? wdata[14]  : pinc_q;
    skip_pre = ctl_wr ? wdata[10]  : pre_dis_q;
    payload  = (kind == FK_READ) ? data_q : wdata[15:0];
  end

  assign start   = (kind != FK_NONE);
  assign is_read = (kind == FK_READ);
  assign half    = div_q;
  assign body    = build_body(ext_q, kind, l_pinc, l_port, l_dev, payload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      div_q     <= '0;
      dev_q     <= '0;
      port_q    <= '0;
      pre_dis_q <= 1'b0;
      scan_q    <= 1'b0;
      pinc_q    <= 1'b0;
      data_q    <= '0;
      addr_q    <= '0;
    end else begin
      if (rd_done) data_q <= rd_value;
      if (wr && addr == A_STAT) begin
        ext_q <= wdata[6];
        div_q <= wdata[8 +: DIV_W];
      end
      if (ctl_wr && !(busy && wdata[15])) begin
        dev_q     <= wdata[4:0];
        port_q    <= wdata[9:5];
        pre_dis_q <= wdata[10];
        scan_q    <= wdata[11];
        pinc_q    <= wdata[14];
      end
      if (wr && !busy && addr == A_DATA) data_q <= wdata[15:0];
      if (wr && !busy && addr == A_ADDR) addr_q <= wdata[15:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: begin
        rdata[0]           = busy;
        rdata[1]           = rd_err;
        rdata[6]           = ext_q;
        rdata[8 +: DIV_W]  = div_q;
      end
      A_CTL:  rdata = {16'b0, 1'b0, pinc_q, 2'b0, scan_q, pre_dis_q, port_q, dev_q};
      A_DATA: rdata = {busy, 15'b0, data_q};
      A_ADDR: rdata = {16'b0, addr_q};
      default: rdata = '0;
    endcase
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy && addr == A_ADDR) |=> $stable(addr_q));

  // R11
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/mdio_master_ctrl.sv
module mdio_master_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RSV_WORDS = 12,
  parameter int DIV_W     = 8,
  parameter int PRE_LEN   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic             busy;
  logic             rd_err;
  logic             rd_done;
  logic [15:0]      rd_value;
  logic             start;
  logic [31:0]      body;
  logic             is_read;
  logic             skip_pre;
  logic [DIV_W-1:0] half;

  mdio_regs #(.ADDR_W(ADDR_W), .RSV_WORDS(RSV_WORDS), .DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .busy    (busy),
    .rd_err  (rd_err),
    .rd_done (rd_done),
    .rd_value(rd_value),
    .start   (start),
    .body    (body),
    .is_read (is_read),
    .skip_pre(skip_pre),
    .half    (half)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .body    (body),
    .is_read (is_read),
    .skip_pre(skip_pre),
    .half    (half),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_done (rd_done),
    .rd_value(rd_value),
    .rd_err  (rd_err)
  );

  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_master_ctrl_test.sv
module mdio_master_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0;
  int checks = 0;

  localparam logic [3:0] A_STAT = 4'd12, A_CTL = 4'd13, A_DATA = 4'd14, A_ADDR = 4'd15;

  logic [63:0] cap_o, cap_oe;
  int          cnt = 0;
  int          pre_len = 32;
  logic        phy_on = 1'b0;
  logic        phy_ta2 = 1'b0;
  logic [15:0] phy_data = '0;

  mdio_master_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #5 clk = ~clk;

  // bit monitor: what the master presents at each rising MDC
  always @(posedge mdc) begin
    if (cnt < 64) begin
      cap_o[cnt]  = mdio_o;
      cap_oe[cnt] = mdio_oe;
    end
    cnt = cnt + 1;
  end

  // PHY model: drives its reply after each falling MDC
  always @(negedge mdc) begin
    int k;
    k = cnt - pre_len;
    if (phy_on && k == 15)                 mdio_i = phy_ta2;
    else if (phy_on && k >= 16 && k <= 31) mdio_i = phy_data[31 - k];
    else                                   mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] body_got();
    logic [31:0] g;
    for (int i = 0; i < 32; i++) g[31 - i] = cap_o[pre_len + i];
    return g;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] p, input logic [4:0] d,
                                     input logic [15:0] v);
    return {st, op, p, d, 2'b10, v};
  endfunction

  task automatic arm(input int pl, input logic on);
    cnt = 0; pre_len = pl; phy_on = on; cap_o = '0; cap_oe = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(A_STAT, v); check("R1 status", v, 0);
    rd_reg(A_CTL, v);  check("R1 control", v, 0);
    rd_reg(A_DATA, v); check("R1 data", v, 0);
    rd_reg(A_ADDR, v); check("R1 address", v, 0);
    rd_reg(4'd3, v);   check("R2 reserved word", v, 0);
    check("R1 mdc low", {31'b0, mdc}, 0);
    check("R1 oe low", {31'b0, mdio_oe}, 0);
  endtask

  task automatic t_c22_write();
    logic [31:0] v;
    wr_reg(A_STAT, 32'h0000_0100);
    wr_reg(A_CTL, {22'b0, 5'h03, 5'h11});
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_A5C3);
    rd_reg(A_STAT, v); check("R9 status busy", {31'b0, v[0]}, 1);
    rd_reg(A_DATA, v); check("R9 data bit31 busy", {31'b0, v[31]}, 1);
    wait_idle();
    check("R4 frame length", cnt, 64);
    check("R4 preamble ones", cap_o[31:0], 32'hFFFF_FFFF);
    check("R5 c22 write body", body_got(), mk(2'b01, 2'b01, 5'h03, 5'h11, 16'hA5C3));
    check("R12 driven whole write", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(A_DATA, v); check("R9 busy cleared", v, 32'h0000_A5C3);
    check("R3 mdc idle low", {31'b0, mdc}, 0);
  endtask

  task automatic t_c22_read();
    logic [31:0] v;
    phy_data = 16'h1234; phy_ta2 = 1'b0;
    arm(32, 1'b1);
    wr_reg(A_CTL, {16'b0, 1'b1, 5'b0, 5'h07, 5'h02});
    wait_idle();
    check("R6 c22 read header", body_got() >> 18, mk(2'b01, 2'b10, 5'h07, 5'h02, 16'h0) >> 18);
    check("R12 released from turnaround", {14'b0, cap_oe[63:46]}, 0);
    rd_reg(A_DATA, v); check("R6 read value", v, 32'h0000_1234);
    rd_reg(A_STAT, v); check("R10 no error", {31'b0, v[1]}, 0);
  endtask

  task automatic t_c45_addr();
    logic [31:0] v;
    wr_reg(A_STAT, 32'h0000_0100);
    arm(32, 1'b0);
    wr_reg(A_ADDR, 32'h0000_0BEE);
    repeat (300) @(negedge clk);
    check("R7 c22 address write launches nothing", cnt, 0);
    rd_reg(A_ADDR, v); check("R7 address stored", v, 32'h0000_0BEE);
    wr_reg(A_STAT, 32'h0000_0140);
    wr_reg(A_CTL, {22'b0, 5'h02, 5'h01});
    arm(32, 1'b0);
    wr_reg(A_ADDR, 32'h0000_BEEF);
    wait_idle();
    check("R7 c45 address frame", body_got(), mk(2'b00, 2'b00, 5'h02, 5'h01, 16'hBEEF));
  endtask

  task automatic t_c45_write_read();
    logic [31:0] v;
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_0F0F);
    wait_idle();
    check("R8 c45 write frame", body_got(), mk(2'b00, 2'b01, 5'h02, 5'h01, 16'h0F0F));
    phy_data = 16'hCAFE; phy_ta2 = 1'b0;
    arm(32, 1'b1);
    wr_reg(A_CTL, {16'b0, 1'b1, 5'b0, 5'h02, 5'h01});
    wait_idle();
    check("R8 c45 read opcode", body_got() >> 18, mk(2'b00, 2'b11, 5'h02, 5'h01, 16'h0) >> 18);
    rd_reg(A_DATA, v); check("R8 c45 read value", v, 32'h0000_CAFE);
    phy_data = 16'h5A5A;
    arm(32, 1'b1);
    wr_reg(A_CTL, {16'b0, 1'b1, 1'b1, 2'b0, 1'b1, 1'b0, 5'h02, 5'h01});
    wait_idle();
    check("R8 post-increment opcode", body_got() >> 18, mk(2'b00, 2'b10, 5'h02, 5'h01, 16'h0) >> 18);
    rd_reg(A_CTL, v); check("R13 scan and post-increment stored", v, {16'b0, 1'b0, 1'b1, 2'b0, 1'b1, 1'b0, 5'h02, 5'h01});
    wr_reg(A_STAT, 32'h0000_0100);
    wr_reg(A_CTL, {22'b0, 5'h03, 5'h11});
  endtask

  task automatic t_read_err();
    logic [31:0] v;
    phy_data = 16'h0000; phy_ta2 = 1'b1;
    arm(32, 1'b1);
    wr_reg(A_CTL, {16'b0, 1'b1, 5'b0, 5'h03, 5'h11});
    wait_idle();
    rd_reg(A_STAT, v); check("R10 error flagged", {30'b0, v[1:0]}, 32'h2);
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_0001);
    rd_reg(A_STAT, v); check("R10 error cleared on launch", {30'b0, v[1:0]}, 32'h1);
    wait_idle();
    phy_ta2 = 1'b0;
  endtask

  task automatic t_no_pre();
    wr_reg(A_CTL, {21'b0, 1'b1, 5'h04, 5'h09});
    arm(0, 1'b0);
    wr_reg(A_DATA, 32'h0000_3C3C);
    wait_idle();
    check("R4 skipped preamble length", cnt, 32);
    check("R4 body first", body_got(), mk(2'b01, 2'b01, 5'h04, 5'h09, 16'h3C3C));
    wr_reg(A_CTL, {22'b0, 5'h03, 5'h11});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_7777);
    repeat (20) @(negedge clk);
    wr_reg(A_DATA, 32'h0000_1111);
    wr_reg(A_ADDR, 32'h0000_2222);
    wr_reg(A_CTL, {16'b0, 1'b1, 5'b0, 5'h1F, 5'h1F});
    wait_idle();
    repeat (200) @(negedge clk);
    check("R11 single frame", cnt, 64);
    check("R11 frame unchanged", body_got(), mk(2'b01, 2'b01, 5'h03, 5'h11, 16'h7777));
    rd_reg(A_DATA, v); check("R11 data kept", v, 32'h0000_7777);
    rd_reg(A_ADDR, v); check("R11 address kept", v, 32'h0000_BEEF);
    rd_reg(A_CTL, v);  check("R11 control kept", v, {22'b0, 5'h03, 5'h11});
  endtask

  task automatic t_divider();
    int hi, lo;
    wr_reg(A_STAT, 32'h0000_0300);
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_0000);
    @(posedge mdc);
    hi = 0; lo = 0;
    forever begin @(negedge clk); if (mdc) hi++; else break; end
    lo = 1;
    forever begin @(negedge clk); if (!mdc) lo++; else break; end
    check("R3 mdc high width", hi, 3);
    check("R3 mdc low width", lo, 3);
    wait_idle();
    wr_reg(A_STAT, 32'h0000_0000);
    arm(32, 1'b0);
    wr_reg(A_DATA, 32'h0000_0000);
    @(posedge mdc);
    hi = 0;
    forever begin @(negedge clk); if (mdc) hi++; else break; end
    check("R3 zero divider acts as one", hi, 1);
    wait_idle();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c22_read();
    t_c45_addr();
    t_c45_write_read();
    t_read_err();
    t_no_pre();
    t_busy_ignore();
    t_divider();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule